// File: doc/BRIEF.md
# Asynchronous Byte ROM Read Sequencer

This block sits on the host side of a byte-wide asynchronous ROM that has two active-low controls: a select that powers up and picks the device, and an output enable that only gates the stored byte onto the data pins. The host hands over a 20-bit address with a valid/ready handshake. The block then drives the address, lowers the select, lowers the output enable at the latest point the timing still allows, and waits out the access windows counted in clock cycles. After that it captures the byte and returns it with a one-cycle valid pulse.

Three windows are timed on separate counters: address stable, select low and output enable low. The byte is captured only once all three have run out. After each read both controls return high. The host gets no new ready until the pins have had their float time, so a following read, or a second device on the same data lines, never meets a driven bus. While no request is pending the select stays high and the device sits in its low-power standby.

Every delay is a parameter given in picoseconds. The block turns each one into cycles by rounding up against the clock period. With the defaults (4 ns clock, 45 ns access, 25 ns enable-to-data, 25 ns float) this gives 12 access cycles, 7 enable cycles, 7 float cycles and an enable lead of 5 cycles.

Top module: `prom_rd_ctrl`

## Requirements
- R1: During and right after reset, select and output enable are high, the response valid is low and the request ready is high.
- R2: Whenever the request ready is high, both select and output enable are high, so the device is in standby with its outputs floating.
- R3: A request is accepted at a clock edge where ready and valid are both high. From the next cycle the address output equals the accepted address, select is low and ready is low.
- R4: The address output does not change while select is low.
- R5: Output enable falls exactly the access count minus the enable count (5 with defaults) cycles after select falls. It is never low while select is high.
- R6: The byte is captured in the first cycle in which select and address have been held for the access count (12) and output enable has been low for the enable count (7). The response valid is then a single-cycle pulse 13 cycles after select fell, carrying that byte.
- R7: In the cycle of the response pulse, select and output enable are both high again.
- R8: Ready returns the float count plus one (8) cycles after the response pulse, 21 cycles after select fell. Select therefore stays high for at least the float count between two accesses.
- R9: A request held valid while ready is low is not accepted. It is taken on the first cycle ready is high, so select falls again 22 cycles after its previous fall, and each response carries the byte of its own address.
- R10: The response data holds the last captured byte until the next response pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host has a read request |
| req_addr | input | 20 | Byte address of the request |
| req_ready | output | 1 | Block can accept a request |
| rsp_valid | output | 1 | One-cycle pulse, captured byte on rsp_data |
| rsp_data | output | 8 | Last captured byte |
| mem_addr | output | 20 | Address to the ROM |
| mem_ce_n | output | 1 | Active-low device select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq | input | 8 | Data pins from the ROM |

## Verification
A counter that expires early shows up as a wrong byte in the very response it affects. The bench's ROM model returns the inverted byte until all three windows have truly elapsed. A wrong enable lead or a late release shows within a single access as a misplaced output-enable edge or response pulse, counted cycle by cycle from the select fall. A broken float guard or a lost state appears at the next request as a ready that returns at the wrong cycle, a second select fall that comes too early, or a held request that is taken twice.

// File: rtl/prom_rd_pkg.sv
package prom_rd_pkg;

    // Convert a delay in picoseconds to whole clock cycles, rounding up.
    function automatic int unsigned cyc_ceil(input int unsigned dly_ps, input int unsigned clk_ps);
        return (dly_ps + clk_ps - 1) / clk_ps;
    endfunction

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_FLOAT  = 2'd2
    } rd_state_e;

endpackage

// File: rtl/prom_dly_cnt.sv
// Saturating cycle counter: held at zero while clr is high, then counts up to LIMIT.
module prom_dly_cnt #(
    parameter int unsigned LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic done
);
    localparam int unsigned CW = $clog2(LIMIT + 2);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (cnt_q < LIM) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign done = (cnt_q >= LIM);
endmodule

// File: rtl/prom_rd_fsm.sv
// Sequencer: accepts a request, drives the controls, captures the byte, guards the float time.
module prom_rd_fsm
    import prom_rd_pkg::*;
#(
    parameter int unsigned AW           = 20,
    parameter int unsigned DW           = 8,
    parameter bit          OE_AT_SELECT = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    output logic          req_ready,
    input  logic          lead_done,
    input  logic          acc_done,
    input  logic          flt_done,
    input  logic [DW-1:0] mem_dq,
    output logic          load,
    output logic [AW-1:0] mem_addr,
    output logic          mem_ce_n,
    output logic          mem_oe_n,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data
);
    typedef struct packed {
        rd_state_e     st;
        logic [AW-1:0] addr;
        logic          ce_n;
        logic          oe_n;
        logic          vld;
        logic [DW-1:0] data;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d     = seq_q;
        seq_d.vld = 1'b0;
        load      = 1'b0;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    load       = 1'b1;
                    seq_d.st   = ST_ACCESS;
                    seq_d.addr = req_addr;
                    seq_d.ce_n = 1'b0;
                    seq_d.oe_n = !OE_AT_SELECT;
                end
            end
            ST_ACCESS: begin
                if (lead_done) begin
                    seq_d.oe_n = 1'b0;
                end
                if (acc_done) begin
                    seq_d.data = mem_dq;
                    seq_d.vld  = 1'b1;
                    seq_d.ce_n = 1'b1;
                    seq_d.oe_n = 1'b1;
                    seq_d.st   = ST_FLOAT;
                end
            end
            ST_FLOAT: begin
                if (flt_done) begin
                    seq_d.st = ST_IDLE;
                end
            end
            default: begin
                seq_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.st   <= ST_IDLE;
            seq_q.addr <= '0;
            seq_q.ce_n <= 1'b1;
            seq_q.oe_n <= 1'b1;
            seq_q.vld  <= 1'b0;
            seq_q.data <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign req_ready = (seq_q.st == ST_IDLE);
    assign mem_addr  = seq_q.addr;
    assign mem_ce_n  = seq_q.ce_n;
    assign mem_oe_n  = seq_q.oe_n;
    assign rsp_valid = seq_q.vld;
    assign rsp_data  = seq_q.data;
endmodule

// File: rtl/prom_rd_ctrl.sv
// Top: cycle-counted read controller for an asynchronous byte ROM.
module prom_rd_ctrl
    import prom_rd_pkg::*;
#(
    parameter int unsigned ADDR_W    = 20,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned CLK_PS    = 4000,
    parameter int unsigned T_ACC_PS  = 45000,
    parameter int unsigned T_OE_PS   = 25000,
    parameter int unsigned T_FLT_PS  = 25000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    input  logic [DATA_W-1:0] mem_dq
);
    localparam int unsigned ACC_CYC  = cyc_ceil(T_ACC_PS, CLK_PS);
    localparam int unsigned OE_CYC   = cyc_ceil(T_OE_PS, CLK_PS);
    localparam int unsigned FLT_CYC  = cyc_ceil(T_FLT_PS, CLK_PS);
    localparam int unsigned OE_LEAD  = (ACC_CYC > OE_CYC) ? ACC_CYC - OE_CYC : 0;
    localparam int unsigned LEAD_LIM = (OE_LEAD > 0) ? OE_LEAD - 1 : 0;

    logic load;
    logic lead_done, addr_done, sel_done, oe_done, flt_done;

    // Enable lead: counted from the accept so the enable edge lands exactly OE_LEAD cycles later.
    prom_dly_cnt #(.LIMIT(LEAD_LIM)) lead_cnt_i (
        .clk(clk), .rst_n(rst_n), .clr(load), .done(lead_done));

    // Address-stable window, restarted whenever a new address is loaded.
    prom_dly_cnt #(.LIMIT(ACC_CYC)) addr_cnt_i (
        .clk(clk), .rst_n(rst_n), .clr(load), .done(addr_done));

    // Select-low window.
    prom_dly_cnt #(.LIMIT(ACC_CYC)) sel_cnt_i (
        .clk(clk), .rst_n(rst_n), .clr(mem_ce_n), .done(sel_done));

    // Output-enable-low window.
    prom_dly_cnt #(.LIMIT(OE_CYC)) oe_cnt_i (
        .clk(clk), .rst_n(rst_n), .clr(mem_oe_n), .done(oe_done));

    // Float guard: runs only while both controls are released.
    prom_dly_cnt #(.LIMIT(FLT_CYC)) flt_cnt_i (
        .clk(clk), .rst_n(rst_n), .clr(!(mem_ce_n && mem_oe_n)), .done(flt_done));

    prom_rd_fsm #(
        .AW(ADDR_W),
        .DW(DATA_W),
        .OE_AT_SELECT(OE_LEAD == 0)
    ) fsm_i (
        .clk(clk),
        .rst_n(rst_n),
        .req_valid(req_valid),
        .req_addr(req_addr),
        .req_ready(req_ready),
        .lead_done(lead_done),
        .acc_done(addr_done && sel_done && oe_done),
        .flt_done(flt_done),
        .mem_dq(mem_dq),
        .load(load),
        .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n),
        .mem_oe_n(mem_oe_n),
        .rsp_valid(rsp_valid),
        .rsp_data(rsp_data)
    );
endmodule

// File: rtl/prom_rd_ctrl_chk.sv
// Port-level protocol checker, bound to prom_rd_ctrl.
module prom_rd_ctrl_chk #(
    parameter int unsigned AW      = 20,
    parameter int unsigned ACC_CYC = 12,
    parameter int unsigned OE_CYC  = 7,
    parameter int unsigned FLT_CYC = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic [AW-1:0] req_addr,
    input logic          req_ready,
    input logic          rsp_valid,
    input logic [AW-1:0] mem_addr,
    input logic          mem_ce_n,
    input logic          mem_oe_n
);
    logic [15:0] sel_run_q, oe_run_q, gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_run_q <= '0;
            oe_run_q  <= '0;
            gap_q     <= 16'(FLT_CYC);
        end else begin
            sel_run_q <= mem_ce_n ? '0 : ((sel_run_q < 16'(ACC_CYC)) ? sel_run_q + 1'b1 : sel_run_q);
            oe_run_q  <= mem_oe_n ? '0 : ((oe_run_q < 16'(OE_CYC)) ? oe_run_q + 1'b1 : oe_run_q);
            gap_q     <= !mem_ce_n ? '0 : ((gap_q < 16'(FLT_CYC)) ? gap_q + 1'b1 : gap_q);
        end
    end

    // R2
    standby_when_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && mem_oe_n));

    // R3
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid) |=> (!mem_ce_n && !req_ready && mem_addr == $past(req_addr)));

    // R4
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

    // R5
    oe_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_ce_n);

    // R6
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R6
    window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (sel_run_q >= 16'(ACC_CYC) && oe_run_q >= 16'(OE_CYC)));

    // R7
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (mem_ce_n && mem_oe_n));

    // R8
    float_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_ce_n) |-> (gap_q >= 16'(FLT_CYC)));
endmodule

bind prom_rd_ctrl prom_rd_ctrl_chk #(
    .AW(ADDR_W),
    .ACC_CYC(ACC_CYC),
    .OE_CYC(OE_CYC),
    .FLT_CYC(FLT_CYC)
) chk_i (
    .clk(clk),
    .rst_n(rst_n),
    .req_valid(req_valid),
    .req_addr(req_addr),
    .req_ready(req_ready),
    .rsp_valid(rsp_valid),
    .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n),
    .mem_oe_n(mem_oe_n)
);

// File: tb/prom_rd_ctrl_tb_top.sv
`timescale 1ns/1ps
module prom_rd_ctrl_tb_top;
    // Timing expectations derived from the requirements (4 ns clock).
    localparam int ACC_K = (45 + 3) / 4;   // 12
    localparam int OE_K  = (25 + 3) / 4;   // 7
    localparam int OE_AT = ACC_K - OE_K;   // 5
    localparam int RSP_AT = ACC_K + 1;     // 13
    localparam int RDY_AT = RSP_AT + OE_K + 1; // 21

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [19:0] req_addr = '0;
    logic        req_ready, rsp_valid, mem_ce_n, mem_oe_n;
    logic [7:0]  rsp_data, mem_dq;
    logic [19:0] mem_addr;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    prom_rd_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_dq(mem_dq)
    );

    // Behavioural ROM: correct byte only after the access windows, inverted byte before.
    function automatic logic [7:0] rom_byte(input logic [19:0] a);
        return a[7:0] ^ a[15:8] ^ {a[19:16], a[19:16]} ^ 8'h5A;
    endfunction

    logic [7:0] sel_age = '0;
    logic [7:0] oe_age  = '0;
    always @(posedge clk) begin
        sel_age <= mem_ce_n ? 8'd0 : ((sel_age < 8'd255) ? sel_age + 8'd1 : sel_age);
        oe_age  <= (mem_oe_n || mem_ce_n) ? 8'd0 : ((oe_age < 8'd255) ? oe_age + 8'd1 : oe_age);
    end
    assign mem_dq = (sel_age >= 8'(ACC_K) && oe_age >= 8'(OE_K)) ? rom_byte(mem_addr) : ~rom_byte(mem_addr);

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(mem_ce_n && mem_oe_n, "R1", "controls high in reset", {mem_ce_n, mem_oe_n}, 2'b11);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_ce_n && mem_oe_n, "R1", "controls high after reset", {mem_ce_n, mem_oe_n}, 2'b11);
        chk(!rsp_valid, "R1", "no response after reset", rsp_valid, 0);
        chk(req_ready, "R1", "ready after reset", req_ready, 1);
    endtask

    task automatic t_idle();
        int bad = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (!(req_ready && mem_ce_n && mem_oe_n)) bad++;
        end
        chk(bad == 0, "R2", "standby cycles violated while idle", bad, 0);
    endtask

    task automatic t_single(input logic [19:0] a);
        int k_oe = -1, k_rsp = -1, k_rdy = -1, pulses = 0;
        bit moved = 1'b0, rel = 1'b0, oe_early = 1'b0;
        logic [7:0] got = '0;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
        req_addr  = ~a;
        chk(!mem_ce_n && !req_ready, "R3", "select low and ready low after accept", {mem_ce_n, req_ready}, 0);
        chk(mem_addr == a, "R3", "address driven", mem_addr, a);
        for (int k = 1; k <= 30; k++) begin
            @(negedge clk);
            if (!mem_oe_n && mem_ce_n) oe_early = 1'b1;
            if (!mem_oe_n && k_oe < 0) k_oe = k;
            if (rsp_valid) begin
                pulses++;
                if (k_rsp < 0) begin
                    k_rsp = k;
                    got   = rsp_data;
                    rel   = mem_ce_n && mem_oe_n;
                end
            end
            if (!mem_ce_n && mem_addr != a) moved = 1'b1;
            if (req_ready && k_rdy < 0) k_rdy = k;
        end
        chk(!moved, "R4", "address changed while selected", moved, 0);
        chk(k_oe == OE_AT, "R5", "output enable fall cycle", k_oe, OE_AT);
        chk(!oe_early, "R5", "output enable low without select", oe_early, 0);
        chk(k_rsp == RSP_AT, "R6", "response cycle", k_rsp, RSP_AT);
        chk(pulses == 1, "R6", "response pulse count", pulses, 1);
        chk(got == rom_byte(a), "R6", "response byte", got, rom_byte(a));
        chk(rel, "R7", "controls released at response", rel, 1);
        chk(k_rdy == RDY_AT, "R8", "ready return cycle", k_rdy, RDY_AT);
        chk(rsp_data == rom_byte(a), "R10", "response byte held", rsp_data, rom_byte(a));
    endtask

    task automatic t_back_to_back(input logic [19:0] a, input logic [19:0] b);
        int falls = 0, k_fall = -1, n_rsp = 0, k_r1 = -1, k_r2 = -1;
        logic [7:0] d1 = '0, d2 = '0;
        bit prev_ce = 1'b0;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_addr = b;
        prev_ce  = mem_ce_n;
        for (int k = 1; k <= 50; k++) begin
            @(negedge clk);
            if (prev_ce && !mem_ce_n) begin
                falls++;
                if (k_fall < 0) k_fall = k;
                req_valid = 1'b0;
            end
            prev_ce = mem_ce_n;
            if (rsp_valid) begin
                n_rsp++;
                if (n_rsp == 1) begin k_r1 = k; d1 = rsp_data; end
                if (n_rsp == 2) begin k_r2 = k; d2 = rsp_data; end
            end
        end
        req_valid = 1'b0;
        chk(falls == 1, "R9", "extra accepts of a held request", falls, 1);
        chk(k_fall == RDY_AT + 1, "R9", "second select fall cycle", k_fall, RDY_AT + 1);
        chk(k_r1 == RSP_AT && d1 == rom_byte(a), "R9", "first response byte", d1, rom_byte(a));
        chk(k_r2 == RDY_AT + 1 + RSP_AT && d2 == rom_byte(b), "R9", "second response byte", d2, rom_byte(b));
        chk(n_rsp == 2, "R6", "responses in back-to-back run", n_rsp, 2);
    endtask

    initial begin
        t_reset();
        t_idle();
        t_single(20'h00000);
        t_single(20'hFFFFF);
        t_single(20'h12345);
        t_single(20'hA5A5A);
        t_back_to_back(20'h0F0F0, 20'h3C3C3);
        t_idle();
        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish actual=%0d expected=%0d", 200000, 0);
            summary();
            $finish;
        end
    end
endmodule